// File: doc/BRIEF.md
# Carry-Skip Adder-Subtractor

This block adds or subtracts two 48-bit two's-complement operands. It produces the sum, the carry out of the most significant bit and a signed overflow flag. The carry path is cut into thirteen skip groups. Inside a group the carry ripples through full adders. When every bit of a group propagates, the group's incoming carry is passed straight to the group's output through a bypass, so the worst-case carry jumps over whole groups and does not travel through all 48 bit cells.

To subtract, the block inverts the second operand and changes the carry injected at the least significant stage. The carry-enable input acts as a carry-in during addition and as a borrow-in during subtraction, so longer words can be chained. Results can be captured in an output register that has a synchronous active-high reset. When the register is left out, the outputs are purely combinational.

Top module: `csk_addsub`

## Requirements
- R1: With `sub_en`=0, `sum_out` equals (`a_in` + `b_in` + `cin_en`) mod 2^48. With `cin_en`=0 the injected carry is 0.
- R2: With `sub_en`=1, `sum_out` equals (`a_in` − `b_in` − `cin_en`) mod 2^48. This is computed as `a_in` + ~`b_in` plus an injected carry of 1 when `cin_en`=0, and 0 when `cin_en`=1.
- R3: `cout_out` is bit 48 of the unsigned 49-bit sum of `a_in`, the (possibly inverted) second operand and the injected carry. During subtraction, 1 means no borrow.
- R4: `ovf_out` is 1 exactly when `a_in` and the effective second operand have the same sign bit (bit 47) and the sign bit of `sum_out` differs from it. This covers both the positive-to-negative and the negative-to-positive directions.
- R5: A carry injected at bit 0 into a fully propagating operand pair passes through all thirteen groups. All-ones plus a carry gives `sum_out`=0 and `cout_out`=1.
- R6: With `REG_OUT`=1, the outputs show the result of the inputs present at the previous rising clock edge. While `rst`=1 at an edge, all three outputs become 0 after that edge.
- R7: The groups are 4 bits wide for the 9 least significant groups and 3 bits wide for the 4 upper groups. A carry generated just below any bit position k, from 1 to 47, reaches bit k, so ((2^k)−1)+1 = 2^k for every k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | 48 | First operand (minuend when subtracting) |
| b_in | input | 48 | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| cin_en | input | 1 | Carry-in when adding, borrow-in when subtracting |
| sum_out | output | 48 | Result word |
| cout_out | output | 1 | Carry out of bit 47 |
| ovf_out | output | 1 | Signed overflow |

## Verification
The hardest case to reach from the ports is a carry that starts at bit 0 and must cross every group through the skip bypasses. Every one of the 48 bit pairs has to propagate at the same moment, which random operands almost never produce. The stimulus reaches this case directly in two ways: all-ones plus an injected carry, and subtraction of an operand from itself, which makes every bit pair complementary. Single-boundary carries are then walked across every bit position, and both overflow directions are driven in add and subtract modes.

// File: rtl/csk_pkg.sv
package csk_pkg;

  // Low bit index of group g: wide groups first from the LSB, then narrow ones.
  function automatic int grp_lo(input int g, input int n_wide, input int w_wide, input int w_narrow);
    if (g <= n_wide) return g * w_wide;
    return n_wide * w_wide + (g - n_wide) * w_narrow;
  endfunction

  function automatic int grp_width(input int g, input int n_wide, input int w_wide, input int w_narrow);
    if (g < n_wide) return w_wide;
    return w_narrow;
  endfunction

endpackage

// File: rtl/csk_group.sv
module csk_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);

  logic [W:0]   rip;
  logic [W-1:0] prop;
  logic         grp_prop;

  always_comb begin
    rip[0] = c_i;
    for (int i = 0; i < W; i++) begin
      prop[i]    = a_i[i] ^ b_i[i];
      s_o[i]     = prop[i] ^ rip[i];
      rip[i+1]   = (a_i[i] & b_i[i]) | (prop[i] & rip[i]);
    end
  end

  assign grp_prop = &prop;
  // bypass: a fully propagating group forwards its incoming carry directly
  assign c_o = rip[W] | (grp_prop & c_i);

endmodule

// File: rtl/csk_chain.sv
module csk_chain
  import csk_pkg::*;
#(
  parameter int N_WIDE   = 9,
  parameter int W_WIDE   = 4,
  parameter int N_NARROW = 4,
  parameter int W_NARROW = 3,
  localparam int N_GRP   = N_WIDE + N_NARROW,
  localparam int WIDTH   = N_WIDE * W_WIDE + N_NARROW * W_NARROW
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int LO = grp_lo(g, N_WIDE, W_WIDE, W_NARROW);
    localparam int GW = grp_width(g, N_WIDE, W_WIDE, W_NARROW);
    logic c_in;
    logic c_out;
    if (g == 0) begin : g_first
      assign c_in = c_i;
    end else begin : g_next
      assign c_in = g_grp[g-1].c_out;
    end
    csk_group #(.W(GW)) u_grp (
      .a_i (a_i[LO +: GW]),
      .b_i (b_i[LO +: GW]),
      .c_i (c_in),
      .s_o (s_o[LO +: GW]),
      .c_o (c_out)
    );
  end

  assign c_o = g_grp[N_GRP-1].c_out;

endmodule

// File: rtl/csk_addsub.sv
module csk_addsub #(
  parameter int N_WIDE   = 9,
  parameter int W_WIDE   = 4,
  parameter int N_NARROW = 4,
  parameter int W_NARROW = 3,
  parameter bit REG_OUT  = 1'b1,
  localparam int WIDTH   = N_WIDE * W_WIDE + N_NARROW * W_NARROW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             sub_en,
  input  logic             cin_en,
  output logic [WIDTH-1:0] sum_out,
  output logic             cout_out,
  output logic             ovf_out
);

  logic [WIDTH-1:0] b_eff;
  logic             c_inj;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;
  logic             c_into_msb;
  logic             ovf_c;

  assign b_eff = b_in ^ {WIDTH{sub_en}};
  // add: carry-in as given; subtract: 1 minus borrow
  assign c_inj = sub_en ^ cin_en;

  csk_chain #(
    .N_WIDE   (N_WIDE),
    .W_WIDE   (W_WIDE),
    .N_NARROW (N_NARROW),
    .W_NARROW (W_NARROW)
  ) u_chain (
    .a_i (a_in),
    .b_i (b_eff),
    .c_i (c_inj),
    .s_o (sum_c),
    .c_o (cout_c)
  );

  // carry entering the sign bit, recovered from its sum bit
  assign c_into_msb = sum_c[WIDTH-1] ^ a_in[WIDTH-1] ^ b_eff[WIDTH-1];
  assign ovf_c      = c_into_msb ^ cout_c;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_out  <= '0;
        cout_out <= 1'b0;
        ovf_out  <= 1'b0;
      end else begin
        sum_out  <= sum_c;
        cout_out <= cout_c;
        ovf_out  <= ovf_c;
      end
    end
  end else begin : g_comb
    assign sum_out  = sum_c;
    assign cout_out = cout_c;
    assign ovf_out  = ovf_c;
  end

endmodule

// File: rtl/csk_addsub_chk.sv
module csk_addsub_chk #(
  parameter int WIDTH   = 48,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             sub_en,
  input logic             cin_en,
  input logic [WIDTH-1:0] sum_out,
  input logic             cout_out,
  input logic             ovf_out
);

  logic [WIDTH-1:0] ref_b;
  logic [WIDTH:0]   ref_full;
  logic             ref_ovf;

  always_comb begin
    ref_b    = sub_en ? ~b_in : b_in;
    ref_full = {1'b0, a_in} + {1'b0, ref_b} + {{WIDTH{1'b0}}, sub_en ^ cin_en};
    ref_ovf  = (a_in[WIDTH-1] == ref_b[WIDTH-1]) && (ref_full[WIDTH-1] != a_in[WIDTH-1]);
  end

  if (REG_OUT) begin : g_seq
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sum_out == $past(ref_full[WIDTH-1:0]))); // R1 R2
    AST_COUT_MATCH: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cout_out == $past(ref_full[WIDTH]))); // R3
    AST_OVF_MATCH: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ovf_out == $past(ref_ovf))); // R4
    AST_FULL_PROP: assert property (@(posedge clk) disable iff (rst)
      ((a_in ^ ref_b) == '1 && (sub_en ^ cin_en)) |=> (sum_out == '0 && cout_out)); // R5
    AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> (sum_out == '0 && !cout_out && !ovf_out)); // R6
  end else begin : g_cmb
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
      sum_out == ref_full[WIDTH-1:0]); // R1 R2
    AST_COUT_MATCH: assert property (@(posedge clk) disable iff (rst)
      cout_out == ref_full[WIDTH]); // R3
    AST_OVF_MATCH: assert property (@(posedge clk) disable iff (rst)
      ovf_out == ref_ovf); // R4
    AST_FULL_PROP: assert property (@(posedge clk) disable iff (rst)
      ((a_in ^ ref_b) == '1 && (sub_en ^ cin_en)) |-> (sum_out == '0 && cout_out)); // R5
  end

endmodule

bind csk_addsub csk_addsub_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .b_in     (b_in),
  .sub_en   (sub_en),
  .cin_en   (cin_en),
  .sum_out  (sum_out),
  .cout_out (cout_out),
  .ovf_out  (ovf_out)
);

// File: tb/csk_addsub_bench.sv
`timescale 1ns/1ps
module csk_addsub_bench;

  localparam int W = 48;
  localparam real HALF = 2.5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         sub_en = 1'b0;
  logic         cin_en = 1'b0;
  logic [W-1:0] sum_out;
  logic         cout_out;
  logic         ovf_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(HALF) clk = ~clk;

  csk_addsub u_csk_addsub (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .sub_en(sub_en), .cin_en(cin_en),
    .sum_out(sum_out), .cout_out(cout_out), .ovf_out(ovf_out)
  );

  // Drive at a falling edge, result registered at the next rising edge,
  // sampled at the following falling edge.
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input logic c, input string req);
    logic [W-1:0] bb;
    logic [W:0]   full;
    logic         e_ovf;
    @(negedge clk);
    a_in = a; b_in = b; sub_en = s; cin_en = c;
    bb    = s ? ~b : b;
    full  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, s ^ c};
    e_ovf = (a[W-1] == bb[W-1]) && (full[W-1] != a[W-1]);
    @(negedge clk);
    n_chk++;
    if (sum_out !== full[W-1:0] || cout_out !== full[W] || ovf_out !== e_ovf) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h sub=%b cin=%b got sum=%h c=%b v=%b exp sum=%h c=%b v=%b",
               req, a, b, s, c, sum_out, cout_out, ovf_out, full[W-1:0], full[W], e_ovf);
    end
  endtask

  task automatic expect_flags(input logic [W-1:0] es, input logic ec, input logic ev,
                              input string req);
    n_chk++;
    if (sum_out !== es || cout_out !== ec || ovf_out !== ev) begin
      n_bad++;
      $display("FAIL %s: got sum=%h c=%b v=%b exp sum=%h c=%b v=%b",
               req, sum_out, cout_out, ovf_out, es, ec, ev);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a_in = '1; b_in = '1; cin_en = 1'b1;
    repeat (3) @(negedge clk);
    expect_flags('0, 1'b0, 1'b0, "R6 reset clear");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add();
    apply(48'h0000_0000_0003, 48'h0000_0000_0004, 1'b0, 1'b0, "R1 small add");
    apply(48'h0000_0000_0003, 48'h0000_0000_0004, 1'b0, 1'b1, "R1 add with carry");
    apply(48'h1234_5678_9ABC, 48'h0FED_CBA9_8765, 1'b0, 1'b0, "R1 mixed add");
    apply(48'hFFFF_0000_FFFF, 48'h0001_FFFF_0001, 1'b0, 1'b0, "R3 carry out");
  endtask

  task automatic t_sub();
    apply(48'h0000_0000_0010, 48'h0000_0000_0003, 1'b1, 1'b0, "R2 small sub");
    apply(48'h0000_0000_0010, 48'h0000_0000_0003, 1'b1, 1'b1, "R2 sub with borrow");
    apply(48'h0000_0000_0003, 48'h0000_0000_0010, 1'b1, 1'b0, "R3 sub borrow out");
    apply(48'h0000_0000_0000, 48'h0000_0000_0000, 1'b1, 1'b1, "R2 zero minus borrow");
  endtask

  task automatic t_propagate();
    @(negedge clk);
    a_in = '1; b_in = '0; sub_en = 1'b0; cin_en = 1'b1;
    @(negedge clk);
    expect_flags('0, 1'b1, 1'b0, "R5 all ones plus carry");
    apply('1, 48'h0, 1'b0, 1'b1, "R5 all ones plus carry model");
    apply(48'hA5A5_5A5A_F00F, 48'hA5A5_5A5A_F00F, 1'b1, 1'b0, "R5 self subtract");
    apply(48'h5555_5555_5555, 48'hAAAA_AAAA_AAAA, 1'b0, 1'b1, "R5 alternating propagate");
  endtask

  task automatic t_overflow();
    @(negedge clk);
    a_in = 48'h7FFF_FFFF_FFFF; b_in = 48'h1; sub_en = 1'b0; cin_en = 1'b0;
    @(negedge clk);
    expect_flags(48'h8000_0000_0000, 1'b0, 1'b1, "R4 positive overflow");
    apply(48'h8000_0000_0000, 48'h8000_0000_0000, 1'b0, 1'b0, "R4 negative overflow");
    apply(48'h8000_0000_0000, 48'h1, 1'b1, 1'b0, "R4 sub negative overflow");
    apply(48'h7FFF_FFFF_FFFF, '1, 1'b1, 1'b0, "R4 sub positive overflow");
    apply(48'h7FFF_FFFF_FFFF, 48'h8000_0000_0000, 1'b0, 1'b0, "R4 mixed signs no overflow");
  endtask

  task automatic t_boundaries();
    for (int k = 1; k < W; k++) begin
      apply((48'h1 << k) - 48'h1, 48'h1, 1'b0, 1'b0, "R7 carry into bit k");
      apply((48'h1 << k) - 48'h1, 48'h0, 1'b0, 1'b1, "R7 injected carry to bit k");
    end
  endtask

  task automatic t_mixed();
    logic [63:0] st = 64'h0123_4567_89AB_CDEF;
    logic [W-1:0] a;
    for (int i = 0; i < 200; i++) begin
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407;
      a  = st[63:16];
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407;
      apply(a, st[63:16], st[3], st[7], "R1 R2 R3 R4 mixed vectors");
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_propagate();
    t_overflow();
    t_boundaries();
    t_mixed();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    expect_flags('0, 1'b0, 1'b0, "R6 reset after activity");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule